// File: doc/BRIEF.md
# AXI-Lite to Wishbone Bridge

This block sits between an AXI4-Lite master and a classic Wishbone slave. Each AXI4-Lite transaction turns into exactly one Wishbone cycle with a single beat. The bridge takes requests on the three AXI-Lite request channels. It keeps the address and data it has captured until it can issue the bus cycle. It then drives one Wishbone transfer and returns the result on the write-response or read-data channel.

Only one transaction is in flight at a time. The write address and the write data may arrive in separate handshakes, in any order and separated by idle cycles. Each is held in its own capture slot until both are present. The Wishbone side has a single select bit, not byte lanes. Responses are always OKAY. Each response stays valid until the AXI master accepts it. Address and data widths are parameters.

Top module: `axil_wb_xlat`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the first cycle after it is released, `s_bvalid`, `s_rvalid` and `m_cyc` are 0. Once the bridge is idle with no captured channel, `s_awready`, `s_wready` and `s_arready` are 1.
- R2: The write-address and write-data handshakes may complete in different, non-adjacent cycles. No Wishbone write starts until the bridge holds both.
- R3: During a Wishbone write, `m_cyc`, `m_stb`, `m_sel` and `m_we` are 1. `m_adr` equals the captured write address unchanged, and `m_dat_o` equals the captured write data.
- R4: In the cycle after `m_ack` is sampled high during a transfer, `m_cyc`, `m_stb` and `m_sel` are 0, so each transaction produces exactly one acknowledged beat.
- R5: After a write is acknowledged, `s_bvalid` rises with `s_bresp` = 2'b00. It stays high until `s_bready` is sampled, and it is 0 in the cycle after that handshake.
- R6: After a read-address handshake, a Wishbone cycle runs with `m_cyc`, `m_stb` and `m_sel` at 1, `m_we` at 0, and `m_adr` equal to the captured read address.
- R7: After a read is acknowledged, `s_rvalid` rises with `s_rresp` = 2'b00 and `s_rdata` equal to `m_dat_i` as sampled on the acknowledging edge. `s_rvalid` stays high until `s_rready` is sampled, and it is 0 in the cycle after that handshake.
- R8: `s_rdata` stays stable while `s_rvalid` is high, even if `m_dat_i` changes.
- R9: A channel's ready signal is 1 only while the bridge is idle and that channel is not already captured. When a complete write and a read address are both held in the same idle cycle, the write is issued first. A read whose address is held while the write data is still missing goes first.
- R10: `s_wstrb`, `s_awprot` and `s_arprot` have no effect. A write with all strobes 0 still places the full write data on `m_dat_o`, and any protection value leaves `m_adr` unchanged.
- R11: While a response is pending (`s_bvalid` or `s_rvalid` high), no ready signal is 1 and `m_cyc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write-address valid |
| s_awready | output | 1 | Write-address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_wvalid | input | 1 | Write-data valid |
| s_wready | output | 1 | Write-data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write strobes (ignored) |
| s_bvalid | output | 1 | Write-response valid |
| s_bready | input | 1 | Write-response ready |
| s_bresp | output | 2 | Write response, always 00 |
| s_arvalid | input | 1 | Read-address valid |
| s_arready | output | 1 | Read-address ready |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_rvalid | output | 1 | Read-data valid |
| s_rready | input | 1 | Read-data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always 00 |
| m_adr | output | ADDR_W | Wishbone address |
| m_dat_o | output | DATA_W | Wishbone write data |
| m_dat_i | input | DATA_W | Wishbone read data |
| m_we | output | 1 | Wishbone write enable |
| m_sel | output | 1 | Wishbone select (single bit) |
| m_stb | output | 1 | Wishbone strobe |
| m_cyc | output | 1 | Wishbone cycle |
| m_ack | input | 1 | Wishbone acknowledge |

## Verification
Completing a write and holding a read address can fall in the same idle cycle. The bench provokes this by raising the write-address, write-data and read-address valids on the same clock, so that all three are captured on one edge. The scoreboard, loaded with the write ahead of the read, then requires the first Wishbone beat to carry `m_we` = 1 at the write address. The opposite case, with the read address and write address captured together and the write data held back, must put the read beat first, and this is judged by the same queue order.

// File: rtl/axwx_pkg.sv
package axwx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WBUS = 3'd1,
        ST_RBUS = 3'd2,
        ST_BRSP = 3'd3,
        ST_RRSP = 3'd4
    } axwx_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axwx_hold.sv
// Capture slot for one request channel: accepts a beat while enabled and
// empty, keeps it until the sequencer consumes it.
module axwx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         valid,
    input  logic         clear,
    input  logic [W-1:0] din,
    output logic         ready,
    output logic         have,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        ready = en && !cur_q.full;
        if (clear) begin
            nxt_d.full = 1'b0;
        end
        if (valid && ready) begin
            nxt_d.full = 1'b1;
            nxt_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign have = cur_q.full;
    assign dout = cur_q.data;

endmodule

// File: rtl/axwx_seq.sv
// Transaction sequencer: picks the next operation, runs one bus beat and
// holds the response until it is taken.
module axwx_seq
    import axwx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_full,
    input  logic rd_full,
    input  logic ack,
    input  logic bready,
    input  logic rready,
    output logic idle,
    output logic issue_wr,
    output logic issue_rd,
    output logic load_rd,
    output logic bus_wr,
    output logic bus_rd,
    output logic bvalid,
    output logic rvalid
);

    typedef struct packed {
        axwx_state_e st;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        issue_wr = 1'b0;
        issue_rd = 1'b0;
        load_rd  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                // a finished write outranks a waiting read
                if (wr_full) begin
                    issue_wr = 1'b1;
                    nxt_d.st = ST_WBUS;
                end else if (rd_full) begin
                    issue_rd = 1'b1;
                    nxt_d.st = ST_RBUS;
                end
            end
            ST_WBUS: if (ack) nxt_d.st = ST_BRSP;
            ST_RBUS: begin
                if (ack) begin
                    load_rd  = 1'b1;
                    nxt_d.st = ST_RRSP;
                end
            end
            ST_BRSP: if (bready) nxt_d.st = ST_IDLE;
            ST_RRSP: if (rready) nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign idle   = (cur_q.st == ST_IDLE);
    assign bus_wr = (cur_q.st == ST_WBUS);
    assign bus_rd = (cur_q.st == ST_RBUS);
    assign bvalid = (cur_q.st == ST_BRSP);
    assign rvalid = (cur_q.st == ST_RRSP);

endmodule

// File: rtl/axwx_rcap.sv
// Read-data register: samples the bus data on the acknowledging edge.
module axwx_rcap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] data;
    } rcap_t;

    rcap_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dout = cur_q.data;

endmodule

// File: rtl/axil_wb_xlat.sv
module axil_wb_xlat
    import axwx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic [ADDR_W-1:0] m_adr,
    output logic [DATA_W-1:0] m_dat_o,
    input  logic [DATA_W-1:0] m_dat_i,
    output logic              m_we,
    output logic              m_sel,
    output logic              m_stb,
    output logic              m_cyc,
    input  logic              m_ack
);

    localparam int STRB_W = DATA_W / 8;

    logic              idle;
    logic              issue_wr, issue_rd, load_rd;
    logic              bus_wr, bus_rd;
    logic              aw_have, w_have, ar_have;
    logic [ADDR_W-1:0] aw_addr, ar_addr;
    logic [DATA_W-1:0] w_data;

    // strobes and protection are accepted but carry no meaning here
    logic [STRB_W+5:0] unused_side;
    assign unused_side = {s_wstrb, s_awprot, s_arprot};

    axwx_hold #(.W(ADDR_W)) u_aw_hold (
        .clk(clk), .rst(rst), .en(idle), .valid(s_awvalid), .clear(issue_wr),
        .din(s_awaddr), .ready(s_awready), .have(aw_have), .dout(aw_addr)
    );

    axwx_hold #(.W(DATA_W)) u_w_hold (
        .clk(clk), .rst(rst), .en(idle), .valid(s_wvalid), .clear(issue_wr),
        .din(s_wdata), .ready(s_wready), .have(w_have), .dout(w_data)
    );

    axwx_hold #(.W(ADDR_W)) u_ar_hold (
        .clk(clk), .rst(rst), .en(idle), .valid(s_arvalid), .clear(issue_rd),
        .din(s_araddr), .ready(s_arready), .have(ar_have), .dout(ar_addr)
    );

    axwx_seq u_seq (
        .clk(clk), .rst(rst),
        .wr_full(aw_have && w_have), .rd_full(ar_have),
        .ack(m_ack), .bready(s_bready), .rready(s_rready),
        .idle(idle), .issue_wr(issue_wr), .issue_rd(issue_rd), .load_rd(load_rd),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bvalid(s_bvalid), .rvalid(s_rvalid)
    );

    axwx_rcap #(.W(DATA_W)) u_rcap (
        .clk(clk), .rst(rst), .load(load_rd), .din(m_dat_i), .dout(s_rdata)
    );

    assign m_cyc   = bus_wr || bus_rd;
    assign m_stb   = m_cyc;
    assign m_sel   = m_cyc;
    assign m_we    = bus_wr;
    assign m_adr   = bus_wr ? aw_addr : ar_addr;
    assign m_dat_o = w_data;
    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/axwx_checks.sv
module axwx_checks #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          awready,
    input logic          wready,
    input logic          arready,
    input logic          bvalid,
    input logic          bready,
    input logic [1:0]    bresp,
    input logic          rvalid,
    input logic          rready,
    input logic [DW-1:0] rdata,
    input logic [1:0]    rresp,
    input logic          cyc,
    input logic          stb,
    input logic          sel,
    input logic          we,
    input logic          ack
);

    // R1: first cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bvalid && !rvalid && !cyc));

    // R3: a write beat carries strobe and select
    a_r3_write_sel: assert property (@(posedge clk) disable iff (rst)
        (cyc && we) |-> (stb && sel));

    // R4: one acknowledged beat per transaction
    a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && ack) |=> (!cyc && !stb && !sel));

    // R5: write response held until taken, then dropped
    a_r5_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));
    a_r5_bvalid_drop: assert property (@(posedge clk) disable iff (rst)
        (bvalid && bready) |=> !bvalid);
    a_r5_bresp_okay: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> (bresp == 2'b00));

    // R7: read response held until taken, then dropped
    a_r7_rvalid_drop: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rready) |=> !rvalid);
    a_r7_rresp_okay: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rresp == 2'b00));

    // R8: read data stable while presented
    a_r8_rdata_stable: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R11: nothing accepted and no bus activity while a response waits
    a_r11_one_inflight: assert property (@(posedge clk) disable iff (rst)
        (bvalid || rvalid) |-> (!awready && !wready && !arready && !cyc));

endmodule

bind axil_wb_xlat axwx_checks #(.DW(DATA_W)) u_checks (
    .clk(clk), .rst(rst),
    .awready(s_awready), .wready(s_wready), .arready(s_arready),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .cyc(m_cyc), .stb(m_stb), .sel(m_sel), .we(m_we), .ack(m_ack)
);

// File: tb/axil_wb_xlat_test.sv
module axil_wb_xlat_test;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [DW-1:0] JUNK = 32'hBAD0_F00D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic          s_bready = 1'b0, s_rready = 1'b0;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic [2:0]    s_awprot = '0, s_arprot = '0;
    logic [DW-1:0] s_wdata = '0;
    logic [DW/8-1:0] s_wstrb = '1;
    logic [DW-1:0] m_dat_i = JUNK;
    logic          m_ack = 1'b0;
    wire           s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
    wire  [1:0]    s_bresp, s_rresp;
    wire  [DW-1:0] s_rdata, m_dat_o;
    wire  [AW-1:0] m_adr;
    wire           m_we, m_sel, m_stb, m_cyc;

    axil_wb_xlat #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_adr(m_adr), .m_dat_o(m_dat_o), .m_dat_i(m_dat_i), .m_we(m_we),
        .m_sel(m_sel), .m_stb(m_stb), .m_cyc(m_cyc), .m_ack(m_ack)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rmodel(input logic [AW-1:0] a);
        return (DW'(a) * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    // scoreboard queues
    typedef struct {
        bit            we;
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
        string         tag;
    } bus_item_t;

    bus_item_t     exp_bus[$];
    logic [DW-1:0] exp_r[$];
    int            exp_b = 0;

    // knobs
    int ack_wait = 0;
    int b_stall = 0;
    int r_stall = 0;

    // Wishbone slave model and bus-side monitor
    bit beat_open = 0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            m_ack = 1'b0;
            beat_open = 0;
        end else if (m_ack) begin
            chk(!m_cyc && !m_stb && !m_sel, "R4 bus idle after ack", {m_cyc, m_stb, m_sel}, 0);
            m_ack = 1'b0;
            beat_open = 0;
            m_dat_i = JUNK;
        end else if (m_cyc && m_stb) begin
            if (!beat_open) begin
                beat_open = 1;
                wait_cnt = 0;
                if (exp_bus.size() == 0) begin
                    chk(0, "R2 unexpected bus beat", m_adr, 0);
                end else begin
                    bus_item_t it;
                    it = exp_bus.pop_front();
                    chk(m_we == it.we, {it.tag, " we"}, m_we, it.we);
                    chk(m_adr == it.adr, {it.tag, " address"}, m_adr, it.adr);
                    chk(m_sel == 1'b1, {it.tag, " sel"}, m_sel, 1);
                    if (it.we) chk(m_dat_o == it.dat, {it.tag, " write data"}, m_dat_o, it.dat);
                end
            end
            if (wait_cnt >= ack_wait) begin
                m_ack = 1'b1;
                if (!m_we) m_dat_i = rmodel(m_adr);
            end else begin
                wait_cnt++;
            end
        end
    end

    // response-side monitor
    bit b_hs = 0, r_hs = 0;
    int b_cnt = 0, r_cnt = 0;
    logic [DW-1:0] r_hold = '0;
    bit r_seen = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (b_hs) begin
                chk(!s_bvalid, "R5 bvalid low after handshake", s_bvalid, 0);
                b_hs = 0; s_bready = 1'b0; b_cnt = 0;
            end else if (s_bvalid) begin
                chk(s_bresp == 2'b00, "R5 bresp OKAY", s_bresp, 0);
                chk(!s_awready && !s_wready && !s_arready && !m_cyc, "R11 quiet while bvalid",
                    {s_awready, s_wready, s_arready, m_cyc}, 0);
                if (b_cnt >= b_stall) begin
                    s_bready = 1'b1; b_hs = 1;
                    chk(exp_b > 0, "R5 expected write response", exp_b, 1);
                    if (exp_b > 0) exp_b--;
                end else begin
                    b_cnt++;
                end
            end
            if (r_hs) begin
                chk(!s_rvalid, "R7 rvalid low after handshake", s_rvalid, 0);
                r_hs = 0; s_rready = 1'b0; r_cnt = 0; r_seen = 0;
            end else if (s_rvalid) begin
                chk(s_rresp == 2'b00, "R7 rresp OKAY", s_rresp, 0);
                if (!r_seen) begin
                    r_seen = 1; r_hold = s_rdata;
                end else begin
                    chk(s_rdata == r_hold, "R8 rdata stable", s_rdata, r_hold);
                end
                if (r_cnt >= r_stall) begin
                    s_rready = 1'b1; r_hs = 1;
                    if (exp_r.size() == 0) begin
                        chk(0, "R7 unexpected read response", s_rdata, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_r.pop_front();
                        chk(s_rdata == e, "R7 read data", s_rdata, e);
                    end
                end else begin
                    r_cnt++;
                end
            end
        end
    end

    // channel drivers
    task automatic send_aw(input logic [AW-1:0] a, input logic [2:0] p);
        @(negedge clk);
        s_awaddr = a; s_awprot = p; s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [DW-1:0] d, input logic [DW/8-1:0] s);
        @(negedge clk);
        s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
        while (!s_wready) @(negedge clk);
        @(negedge clk);
        s_wvalid = 1'b0;
    endtask

    task automatic send_ar(input logic [AW-1:0] a, input logic [2:0] p);
        @(negedge clk);
        s_araddr = a; s_arprot = p; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
    endtask

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        bus_item_t it;
        it.we = 1; it.adr = a; it.dat = d; it.tag = tag;
        exp_bus.push_back(it);
        exp_b++;
    endtask

    task automatic push_rd(input logic [AW-1:0] a, input string tag);
        bus_item_t it;
        it.we = 0; it.adr = a; it.dat = '0; it.tag = tag;
        exp_bus.push_back(it);
        exp_r.push_back(rmodel(a));
    endtask

    task automatic wait_quiet();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while ((exp_bus.size() != 0 || exp_b != 0 || exp_r.size() != 0 ||
                    s_bvalid || s_rvalid || b_hs || r_hs || m_cyc) && k < 2000);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!s_bvalid && !s_rvalid && !m_cyc, "R1 outputs quiet after reset", {s_bvalid, s_rvalid, m_cyc}, 0);
        chk(s_awready && s_wready && s_arready, "R1 readies high when idle",
            {s_awready, s_wready, s_arready}, 3'b111);

        // simple write and read
        push_wr(12'h00C, 32'hDEAD_BEEF, "R3 write");
        fork
            send_aw(12'h00C, 3'd0);
            send_w(32'hDEAD_BEEF, '1);
        join
        wait_quiet();
        push_rd(12'h00D, "R6 read");
        send_ar(12'h00D, 3'd0);
        wait_quiet();

        // R2: address first, data several cycles later
        push_wr(12'h3A5, 32'h0123_4567, "R2 split write");
        send_aw(12'h3A5, 3'd0);
        chk(!s_awready && s_wready, "R9 awready low once captured", {s_awready, s_wready}, 2'b01);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!m_cyc, "R2 no bus cycle before data", m_cyc, 0);
        end
        send_w(32'h0123_4567, '1);
        wait_quiet();

        // data first, address later
        push_wr(12'h0F0, 32'hA5A5_5A5A, "R2 data-first write");
        send_w(32'hA5A5_5A5A, '1);
        chk(!s_wready && s_awready, "R9 wready low once captured", {s_wready, s_awready}, 2'b01);
        repeat (3) @(negedge clk);
        chk(!m_cyc, "R2 no bus cycle before address", m_cyc, 0);
        send_aw(12'h0F0, 3'd0);
        wait_quiet();

        // slow acknowledge and slow response acceptance
        ack_wait = 3; b_stall = 4; r_stall = 5;
        push_wr(12'hFFF, 32'hFFFF_0000, "R5 stalled write");
        fork
            send_aw(12'hFFF, 3'd0);
            send_w(32'hFFFF_0000, '1);
        join
        wait_quiet();
        push_rd(12'h800, "R8 stalled read");
        send_ar(12'h800, 3'd0);
        wait_quiet();
        ack_wait = 0; b_stall = 0; r_stall = 0;

        // R10: zero strobes and odd protection values change nothing
        push_wr(12'h155, 32'hCAFE_F00D, "R10 write strobes ignored");
        fork
            send_aw(12'h155, 3'd7);
            send_w(32'hCAFE_F00D, '0);
        join
        wait_quiet();
        push_rd(12'h2AA, "R10 read protection ignored");
        send_ar(12'h2AA, 3'd5);
        wait_quiet();

        // R9: complete write and read address captured on the same edge
        push_wr(12'h111, 32'h1111_2222, "R9 write ahead of read");
        push_rd(12'h222, "R9 read after write");
        fork
            send_aw(12'h111, 3'd0);
            send_w(32'h1111_2222, '1);
            send_ar(12'h222, 3'd0);
        join
        wait_quiet();

        // R9: read address held while write data is missing goes first
        push_rd(12'h333, "R9 read ahead of incomplete write");
        push_wr(12'h444, 32'h4444_5555, "R9 write after read");
        fork
            send_aw(12'h444, 3'd0);
            send_ar(12'h333, 3'd0);
            begin
                repeat (3) @(negedge clk);
                send_w(32'h4444_5555, '1);
            end
        join
        wait_quiet();

        chk(exp_bus.size() == 0 && exp_b == 0 && exp_r.size() == 0, "R4 all expected items seen",
            exp_bus.size() + exp_b + exp_r.size(), 0);
        chk(s_awready && s_wready && s_arready, "R9 readies high when idle again",
            {s_awready, s_wready, s_arready}, 3'b111);

        // R1: reset in the middle of a captured address clears it
        send_aw(12'h777, 3'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!s_bvalid && !s_rvalid && !m_cyc, "R1 quiet during reset", {s_bvalid, s_rvalid, m_cyc}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(s_awready, "R1 capture flag cleared by reset", s_awready, 1);
        push_wr(12'h778, 32'h7777_8888, "R1 write after reset");
        fork
            send_aw(12'h778, 3'd0);
            send_w(32'h7777_8888, '1);
        join
        wait_quiet();

        finish_run();
    end

endmodule